// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt sources for a small CPU core. The sources are one external request line that is active on its falling edge, three timer overflow pulses and one pulse from a D/A converter whose buffer has gone empty. Each source latches into a pending flag. A flag is serviced only when both its own enable bit and the global enable are set. Among the sources that are ready, the one with the highest fixed priority wins, and its vector address is presented to the core together with a request line.

The core's sequencer answers with an acknowledge. The acknowledge clears the winning flag and the global enable, so one service routine cannot be interrupted by another. The global enable comes back only with a return-from-interrupt strobe. A stack-full input holds off new requests while the return stack has no room left. Requests are evaluated only on a phase strobe from the sequencer, so the request and vector outputs change on that strobe and on an acknowledge, and at no other time. Software reads and writes two byte-wide control registers that hold the enables and the flags.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00 and irq_req is low.
- R2: Register A (reg_sel=0) holds the global enable at bit 0, the external enable at bit 1, the timer 0 enable at bit 2, the external flag at bit 4 and the timer 0 flag at bit 5. Bits 3, 6 and 7 read as 0.
- R3: Register B (reg_sel=1) holds the timer 2 enable at bit 0, the timer 3 enable at bit 1, the D/A enable at bit 2, the timer 2 flag at bit 4, the timer 3 flag at bit 5 and the D/A flag at bit 6. Bits 3 and 7 read as 0.
- R4: The external flag is set by a high-to-low transition of ext_irq_n after a two-flop synchronizer. A low-to-high transition sets nothing.
- R5: A pulse on a timer or D/A input sets its flag whatever the enables hold. If a hardware set and a software write of 0 hit the same flag in one cycle, the flag ends up set.
- R6: Software can write any flag to 0 or 1. A flag that has been set stays set until software clears it or its interrupt is acknowledged.
- R7: The priorities and vectors are fixed: external 0x04 (highest), timer 0 0x08, timer 2 0x10, timer 3 0x14, D/A 0x18 (lowest). irq_vec carries the vector of the winner.
- R8: irq_req and irq_vec are updated only in a cycle with phase_strobe high, or cleared by an acknowledge. Between strobes they hold their values.
- R9: cpu_ack while irq_req is high clears the serviced flag and the global enable, and drops irq_req at the next edge. cpu_ack while irq_req is low has no effect.
- R10: A strobe with stack_full high raises no request. The flag stays pending and is serviced at a later strobe once stack_full is low.
- R11: reti sets the global enable. If an acknowledge happens in the same cycle, the acknowledge wins and the global enable is cleared.
- R12: A source raises irq_req only when its own enable and the global enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_irq_n | input | 1 | External interrupt line, asynchronous, active on its falling edge |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| dac_empty | input | 1 | D/A buffer-empty pulse |
| phase_strobe | input | 1 | Evaluation strobe from the sequencer |
| stack_full | input | 1 | Return stack has no free level |
| cpu_ack | input | 1 | Sequencer takes the pending request |
| reti | input | 1 | Return-from-interrupt executed |
| reg_sel | input | 1 | Register select: 0 = register A, 1 = register B |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the granted source |

## Verification
The assertions assume that the sequencer raises cpu_ack only as an answer to a visible irq_req, and that phase_strobe is a single-cycle pulse. They also assume that stack_full is stable around a strobe, since the block samples it only then. The stimulus follows these rules. It pulses the source inputs for one cycle, holds ext_irq_n steady for several cycles so that the synchronizer sees each level, and issues every acknowledge at least one cycle after the strobe that raised the request. The one deliberate exception is a cpu_ack with no request pending, which checks that such an acknowledge has no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int NSRC      = 5;
  localparam int REG_W     = 8;
  localparam int VEC_W     = 8;
  localparam int VEC_STEP  = 4;
  localparam int VEC_HOLE  = 2;

  // source index doubles as priority: lower index wins
  typedef enum logic [2:0] {
    SRC_EXT = 3'd0,
    SRC_T0  = 3'd1,
    SRC_T2  = 3'd2,
    SRC_T3  = 3'd3,
    SRC_DAC = 3'd4
  } src_e;

  // register A bit positions
  localparam int A_GIE    = 0;
  localparam int A_EN_EXT = 1;
  localparam int A_EN_T0  = 2;
  localparam int A_FL_EXT = 4;
  localparam int A_FL_T0  = 5;

  // register B bit positions
  localparam int B_EN_T2  = 0;
  localparam int B_EN_T3  = 1;
  localparam int B_EN_DAC = 2;
  localparam int B_FL_T2  = 4;
  localparam int B_FL_T3  = 5;
  localparam int B_FL_DAC = 6;

  // vector slots are spaced by VEC_STEP; one slot after timer 0 is left empty
  function automatic logic [VEC_W-1:0] vector_of(input int unsigned idx);
    int unsigned slot;
    slot = (idx < VEC_HOLE) ? idx + 1 : idx + 2;
    return VEC_W'(slot * VEC_STEP);
  endfunction

endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], async_in};
  end

  // idle level is high so leaving reset never looks like an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_pulse = prev_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse); // R4

endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  hw_set,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [REG_W-1:0] wdata,
  input  logic             ack_fire,
  input  logic [NSRC-1:0]  ack_clr,
  input  logic             reti,
  output logic             gie,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  flag,
  output logic [REG_W-1:0] rdata_a,
  output logic [REG_W-1:0] rdata_b
);

  logic            gie_q, gie_n;
  logic [NSRC-1:0] en_q, en_n;
  logic [NSRC-1:0] flag_q, flag_n, flag_sw;
  logic            ctl_upd;
  logic            flag_upd;
  logic            unused_wbits;

  assign unused_wbits = ^{wdata[7], wdata[3]};

  always_comb begin
    gie_n   = gie_q;
    en_n    = en_q;
    flag_sw = flag_q;
    if (wr_a) begin
      gie_n            = wdata[A_GIE];
      en_n[SRC_EXT]    = wdata[A_EN_EXT];
      en_n[SRC_T0]     = wdata[A_EN_T0];
      flag_sw[SRC_EXT] = wdata[A_FL_EXT];
      flag_sw[SRC_T0]  = wdata[A_FL_T0];
    end
    if (wr_b) begin
      en_n[SRC_T2]     = wdata[B_EN_T2];
      en_n[SRC_T3]     = wdata[B_EN_T3];
      en_n[SRC_DAC]    = wdata[B_EN_DAC];
      flag_sw[SRC_T2]  = wdata[B_FL_T2];
      flag_sw[SRC_T3]  = wdata[B_FL_T3];
      flag_sw[SRC_DAC] = wdata[B_FL_DAC];
    end
    if (reti)     gie_n = 1'b1;
    if (ack_fire) gie_n = 1'b0;
    // hardware set is applied last so it beats any clear
    flag_n = (flag_sw & ~(ack_fire ? ack_clr : '0)) | hw_set;
  end

  assign ctl_upd  = wr_a | wr_b | reti | ack_fire;
  assign flag_upd = ctl_upd | (|hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ctl_upd) begin
        gie_q <= gie_n;
        en_q  <= en_n;
      end
      if (flag_upd) flag_q <= flag_n;
    end
  end

  always_comb begin
    rdata_a           = '0;
    rdata_a[A_GIE]    = gie_q;
    rdata_a[A_EN_EXT] = en_q[SRC_EXT];
    rdata_a[A_EN_T0]  = en_q[SRC_T0];
    rdata_a[A_FL_EXT] = flag_q[SRC_EXT];
    rdata_a[A_FL_T0]  = flag_q[SRC_T0];
    rdata_b           = '0;
    rdata_b[B_EN_T2]  = en_q[SRC_T2];
    rdata_b[B_EN_T3]  = en_q[SRC_T3];
    rdata_b[B_EN_DAC] = en_q[SRC_DAC];
    rdata_b[B_FL_T2]  = flag_q[SRC_T2];
    rdata_b[B_FL_T3]  = flag_q[SRC_T3];
    rdata_b[B_FL_DAC] = flag_q[SRC_DAC];
  end

  assign gie  = gie_q;
  assign en   = en_q;
  assign flag = flag_q;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set))); // R5

  AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !gie_q); // R9

  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack_fire) |=> gie_q); // R11

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]  ready,
  output logic [NSRC-1:0]  grant,
  output logic             any,
  output logic [VEC_W-1:0] vector
);

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_pri
      if (gi == 0) begin : g_top
        assign grant[gi] = ready[gi];
      end else begin : g_rest
        assign grant[gi] = ready[gi] & ~(|ready[gi-1:0]);
      end
    end
  endgenerate

  assign any = |ready;

  always_comb begin
    vector = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) vector = vector | vector_of(i);
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_irq_n,
  input  logic             tmr0_ovf,
  input  logic             tmr2_ovf,
  input  logic             tmr3_ovf,
  input  logic             dac_empty,
  input  logic             phase_strobe,
  input  logic             stack_full,
  input  logic             cpu_ack,
  input  logic             reti,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  // reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_STAGES-1];

  logic ext_fall;

  irqc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .async_in   (ext_irq_n),
    .fall_pulse (ext_fall)
  );

  logic [NSRC-1:0] hw_set;
  always_comb begin
    hw_set          = '0;
    hw_set[SRC_EXT] = ext_fall;
    hw_set[SRC_T0]  = tmr0_ovf;
    hw_set[SRC_T2]  = tmr2_ovf;
    hw_set[SRC_T3]  = tmr3_ovf;
    hw_set[SRC_DAC] = dac_empty;
  end

  logic             gie;
  logic [NSRC-1:0]  en, flag;
  logic [REG_W-1:0] rdata_a, rdata_b;
  logic             ack_fire;
  logic [NSRC-1:0]  grant_q, grant_n;
  logic             wr_a, wr_b;

  assign wr_a = reg_wr & ~reg_sel;
  assign wr_b = reg_wr &  reg_sel;

  irqc_flag_bank u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hw_set   (hw_set),
    .wr_a     (wr_a),
    .wr_b     (wr_b),
    .wdata    (reg_wdata),
    .ack_fire (ack_fire),
    .ack_clr  (grant_q),
    .reti     (reti),
    .gie      (gie),
    .en       (en),
    .flag     (flag),
    .rdata_a  (rdata_a),
    .rdata_b  (rdata_b)
  );

  assign reg_rdata = reg_sel ? rdata_b : rdata_a;

  logic [NSRC-1:0]  ready, grant;
  logic             any;
  logic [VEC_W-1:0] vector;

  assign ready = flag & en & {NSRC{gie}};

  irqc_arbiter u_arb (
    .ready  (ready),
    .grant  (grant),
    .any    (any),
    .vector (vector)
  );

  // request stage: loaded on strobe, cleared on acknowledge
  logic             req_q, req_n;
  logic [VEC_W-1:0] vec_q, vec_n;
  logic             take;
  logic             req_upd;

  assign ack_fire = cpu_ack & req_q;
  assign take     = any & ~stack_full;
  assign req_upd  = ack_fire | phase_strobe;

  always_comb begin
    req_n   = req_q;
    vec_n   = vec_q;
    grant_n = grant_q;
    if (ack_fire) begin
      req_n   = 1'b0;
      grant_n = '0;
    end else if (phase_strobe) begin
      req_n   = take;
      vec_n   = take ? vector : vec_q;
      grant_n = take ? grant : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q   <= 1'b0;
      vec_q   <= '0;
      grant_q <= '0;
    end else if (req_upd) begin
      req_q   <= req_n;
      vec_q   <= vec_n;
      grant_q <= grant_n;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant)); // R7

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!phase_strobe && !ack_fire) |=> ($stable(irq_req) && $stable(irq_vec))); // R8

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_fire |=> !irq_req); // R9

  AST_STACK_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_strobe && stack_full) |=> !irq_req); // R10

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq_req) |-> $past(gie)); // R12

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_irq_n, tmr0_ovf, tmr2_ovf, tmr3_ovf, dac_empty;
  logic       phase_strobe, stack_full, cpu_ack, reti;
  logic       reg_sel, reg_wr;
  logic [7:0] reg_wdata, reg_rdata, irq_vec;
  logic       irq_req;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n),
    .tmr0_ovf(tmr0_ovf), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
    .dac_empty(dac_empty), .phase_strobe(phase_strobe),
    .stack_full(stack_full), .cpu_ack(cpu_ack), .reti(reti),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // scoreboard item kinds: 0 = read data, 1 = request only, 2 = {request, vector}
  typedef struct {
    int         kind;
    logic [8:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t      it;
      logic [8:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {1'b0, reg_rdata};
        1:       act = {irq_req, 8'h00};
        default: act = {irq_req, irq_vec};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%03h expected 0x%03h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input int kind, input logic [8:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
    @(negedge clk);
    tick();
  endtask

  task automatic chk_reg(input logic sel, input logic [7:0] exp, input string tag);
    reg_sel = sel;
    expect_item(0, {1'b0, exp}, tag);
  endtask

  task automatic chk_noreq(input string tag);
    expect_item(1, 9'h000, tag);
  endtask

  task automatic chk_vec(input logic [7:0] v, input string tag);
    expect_item(2, {1'b1, v}, tag);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic strobe();
    phase_strobe = 1'b1; tick(); phase_strobe = 1'b0;
  endtask

  task automatic ack();
    cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic pulse_t0();
    tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ext_irq_n = 1'b1;
    tmr0_ovf = 0; tmr2_ovf = 0; tmr3_ovf = 0; dac_empty = 0;
    phase_strobe = 0; stack_full = 0; cpu_ack = 0; reti = 0;
    reg_sel = 0; reg_wr = 0; reg_wdata = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    chk_reg(0, 8'h00, "R1 reg A reset");
    chk_reg(1, 8'h00, "R1 reg B reset");
    chk_noreq("R1 no request after reset");

    pulse_t0();
    chk_reg(0, 8'h20, "R5 timer0 flag set with enables off");
    strobe();
    chk_noreq("R12 disabled source raises no request");

    wr(0, 8'h25);
    chk_reg(0, 8'h25, "R2 register A fields");
    chk_noreq("R8 no request before strobe");
    strobe();
    chk_vec(8'h08, "R7 timer0 vector");
    repeat (2) tick();
    chk_vec(8'h08, "R8 request held between strobes");

    ack();
    chk_noreq("R9 request dropped on ack");
    chk_reg(0, 8'h04, "R9 ack clears flag and global enable");
    ack();
    chk_reg(0, 8'h04, "R9 ack without request ignored");
    do_reti();
    chk_reg(0, 8'h05, "R11 reti sets global enable");

    // three lower sources at once
    tmr2_ovf = 1; tmr3_ovf = 1; dac_empty = 1;
    reg_sel = 1; reg_wr = 1; reg_wdata = 8'h07;
    tick();
    tmr2_ovf = 0; tmr3_ovf = 0; dac_empty = 0; reg_wr = 0;
    chk_reg(1, 8'h77, "R3 register B fields");
    strobe();
    chk_vec(8'h10, "R7 timer2 beats timer3 and D/A");
    ack();
    chk_reg(1, 8'h67, "R9 only timer2 flag cleared");
    do_reti(); strobe();
    chk_vec(8'h14, "R7 timer3 vector");
    ack(); do_reti(); strobe();
    chk_vec(8'h18, "R7 D/A vector");
    ack();
    chk_reg(1, 8'h07, "R9 D/A flag cleared");
    chk_reg(0, 8'h04, "R9 global enable cleared");

    // ack and reti together
    do_reti(); pulse_t0(); strobe();
    chk_vec(8'h08, "R7 timer0 vector again");
    cpu_ack = 1; reti = 1; tick(); cpu_ack = 0; reti = 0;
    chk_reg(0, 8'h04, "R11 ack beats reti");

    // external edge
    wr(0, 8'h07);
    ext_irq_n = 1'b0;
    repeat (4) tick();
    chk_reg(0, 8'h17, "R4 falling edge sets external flag");
    pulse_t0();
    chk_reg(0, 8'h37, "R5 timer0 flag beside external");
    strobe();
    chk_vec(8'h04, "R7 external highest priority");
    ack();
    chk_reg(0, 8'h26, "R9 external flag and enable cleared");
    ext_irq_n = 1'b1;
    repeat (4) tick();
    chk_reg(0, 8'h26, "R4 rising edge sets nothing");

    // stack full
    do_reti();
    stack_full = 1'b1;
    strobe();
    chk_noreq("R10 no request while stack full");
    chk_reg(0, 8'h27, "R10 flag stays pending");
    stack_full = 1'b0;
    strobe();
    chk_vec(8'h08, "R10 serviced after stack frees");
    ack(); do_reti();
    chk_reg(0, 8'h07, "R9 state after service");

    // hardware set against software clear
    reg_sel = 0; reg_wr = 1; reg_wdata = 8'h07; tmr0_ovf = 1;
    tick();
    reg_wr = 0; tmr0_ovf = 0;
    chk_reg(0, 8'h27, "R5 hardware set wins over software clear");
    wr(0, 8'h07);
    chk_reg(0, 8'h07, "R6 software clears flag");
    wr(0, 8'h10);
    chk_reg(0, 8'h10, "R6 software sets flag");
    wr(0, 8'hFF);
    chk_reg(0, 8'h37, "R2 unused bits read 0");
    wr(0, 8'h00);
    wr(1, 8'hFF);
    chk_reg(1, 8'h77, "R3 reserved bits read 0");
    strobe();
    chk_noreq("R12 global enable off blocks request");
    wr(1, 8'h00);
    chk_reg(1, 8'h00, "R6 software clears register B flags");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule